// File: doc/BRIEF.md
# Descriptor-Walking Audio Playback DMA

This block is a bus-master engine that feeds a playback codec. Software writes a table of two-word descriptors into memory and loads the table address into a pointer register. Setting the enable bit in the command register starts the engine. It fetches each descriptor and reads the described memory region one 32-bit word at a time. Each word holds a left and a right sample, and the engine hands the words to the codec side over a valid/ready interface.

Descriptors carry three flags: end of table, end of page and jump. The pointer register is written back as the engine runs, so a read returns the address of the next descriptor. Finishing an end-of-page region raises a status bit and the interrupt. A second end-of-page event before software reads the status register sets an error bit and parks the engine until that read happens. Reading the status register clears both status bits.

Top module: `audio_dma_engine`

## Requirements
- R1: After reset, the command, status and pointer registers read 0, `irq` is low, and neither `mem_req` nor `snd_valid` is asserted.
- R2: The register address selects 0 = command, 1 = status, 2 = table pointer. In the command register, bit 0 is the enable and bit 3 is the direction. All other command bits read as 0.
- R3: The table pointer register keeps bits 31:2 of a write, and bits 1:0 always read as 0.
- R4: When the engine is enabled with direction 0, it fetches its first descriptor from the pointer value and writes that value plus 8 back into the pointer register within two cycles of the command write.
- R5: A descriptor is word 0 = region base address and word 1 with bit 31 = end of table, bit 30 = end of page, bit 29 = jump, and bits 15:0 = byte count. A region delivers the words at base, base+4, and so on, in order. The word count is the byte count divided by 4 and rounded up.
- R6: A byte count of 0 transfers 65536 bytes, which is 16384 words.
- R7: A jump descriptor transfers nothing. Its word 0, with bits 1:0 cleared, becomes the next descriptor address, and the pointer then reads that address plus 8.
- R8: After the last word of an end-of-table region, the engine makes no further memory requests, and the enable bit still reads 1. Clearing the enable bit and setting it again restarts the engine from the pointer register.
- R9: Finishing an end-of-page region sets status bit 0. `irq` is high whenever status bit 0 or status bit 1 is set.
- R10: An end-of-page event that occurs while status bit 0 is set sets status bit 1, and the engine issues no memory request until the status register is read. After that read, the engine continues with the next descriptor.
- R11: A read of the status register returns its value and clears bits 0 and 1.
- R12: Clearing the enable bit during a transfer stops the engine at the next word boundary. After that, no further words or memory requests appear.
- R13: With direction bit 1, setting the enable bit starts nothing: there are no requests and the pointer is not advanced.
- R14: `mem_req` and `mem_addr` hold until `mem_rvalid`, and `snd_valid` and `snd_data` hold until `snd_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (a status read clears the status) |
| reg_addr | input | 2 | Register select: 0 command, 1 status, 2 pointer |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory read request, held until answered |
| mem_addr | output | 32 | Memory read address |
| mem_rvalid | input | 1 | Read data valid, taken while `mem_req` is high |
| mem_rdata | input | 32 | Memory read data |
| snd_valid | output | 1 | Sample word valid toward the codec |
| snd_data | output | 32 | Stereo sample word |
| snd_ready | input | 1 | Codec side accepts the word |
| irq | output | 1 | Status interrupt |

## Verification
The hardest state to reach is the error pause. It needs two end-of-page regions to finish back to back while software deliberately leaves the status register unread. The bench builds a table of two end-of-page regions followed by a short end-of-table region and does not read status. It waits until exactly the first two regions' words have arrived, then checks over a long window that the memory request counter stays frozen and the interrupt stays high. A single status read must then return both bits set and release the last region. Randomly built tables with random byte counts and randomly inserted jumps exercise the walk itself, while random memory latency and random codec back-pressure vary the handshakes.

// File: rtl/adma_pkg.sv
package adma_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_NEXT,
        S_FETCH0,
        S_FETCH1,
        S_DATA_RD,
        S_DATA_PUSH
    } seq_state_e;

    localparam logic [1:0] REG_CMD  = 2'd0;
    localparam logic [1:0] REG_STAT = 2'd1;
    localparam logic [1:0] REG_PTR  = 2'd2;

    localparam int FLAG_EOT = 31;
    localparam int FLAG_EOP = 30;
    localparam int FLAG_JMP = 29;

    localparam int DESC_WORDS = 2;

endpackage

// File: rtl/adma_regs.sv
module adma_regs
    import adma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              cmd_en,
    output logic              cmd_dir,
    output logic [ADDR_W-1:0] ptr,
    output logic              err_flag,
    output logic              irq,
    input  logic              ptr_upd,
    input  logic [ADDR_W-3:0] ptr_upd_val,
    input  logic              eop_event
);

    typedef struct packed {
        logic              en;
        logic              dir;
        logic [ADDR_W-3:0] ptr;
        logic              eop;
        logic              err;
    } regs_t;

    regs_t q, d;
    logic  stat_rd;
    logic  unused_wdata_bit;

    assign unused_wdata_bit = wdata[1];
    assign stat_rd          = rd_en && (addr == REG_STAT);

    always_comb begin
        d = q;
        if (ptr_upd) begin
            d.ptr = ptr_upd_val;
        end
        if (wr_en && addr == REG_PTR) begin
            d.ptr = wdata[ADDR_W-1:2];
        end
        if (wr_en && addr == REG_CMD) begin
            d.en  = wdata[0];
            d.dir = wdata[3];
        end
        if (stat_rd) begin
            d.eop = 1'b0;
            d.err = 1'b0;
        end
        if (eop_event) begin
            if (q.eop && !stat_rd) begin
                d.err = 1'b1;
            end else begin
                d.eop = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (addr)
            REG_CMD:  rdata = REG_W'({4'b0000, q.dir, 2'b00, q.en});
            REG_STAT: rdata = REG_W'({6'b000000, q.err, q.eop});
            REG_PTR:  rdata = REG_W'({q.ptr, 2'b00});
            default:  rdata = '0;
        endcase
    end

    assign cmd_en   = q.en;
    assign cmd_dir  = q.dir;
    assign ptr      = {q.ptr, 2'b00};
    assign err_flag = q.err;
    assign irq      = q.eop | q.err;

    // R10: the error bit only rises when a page flag was already pending
    p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.err) |-> $past(q.eop));

    // R11: a status read with no new event leaves both bits clear
    p_rtc_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !eop_event) |=> (!q.eop && !q.err));

endmodule

// File: rtl/adma_seq.sv
module adma_seq
    import adma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              dir,
    input  logic              pause,
    input  logic [ADDR_W-1:0] ptr,
    output logic              ptr_upd,
    output logic [ADDR_W-3:0] ptr_upd_val,
    output logic              eop_event,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              snd_valid,
    output logic [DATA_W-1:0] snd_data,
    input  logic              snd_ready
);

    localparam int WORD_BYTES = DATA_W / 8;
    localparam int DESC_BYTES = DESC_WORDS * WORD_BYTES;
    localparam int REM_W      = CNT_W + 1;

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] desc;
        logic [ADDR_W-1:0] cur;
        logic [REM_W-1:0]  rem;
        logic              eot;
        logic              eop;
        logic [DATA_W-1:0] word;
        logic              done;
    } seq_t;

    seq_t q, d;
    logic last_word;

    assign last_word = (q.rem <= REM_W'(WORD_BYTES));

    always_comb begin
        d           = q;
        mem_req     = 1'b0;
        mem_addr    = '0;
        snd_valid   = 1'b0;
        snd_data    = q.word;
        ptr_upd     = 1'b0;
        ptr_upd_val = ptr[ADDR_W-1:2] + (ADDR_W-2)'(DESC_BYTES / 4);
        eop_event   = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (!en) begin
                    d.done = 1'b0;
                end else if (!dir && !q.done && !pause) begin
                    d.st    = S_FETCH0;
                    d.desc  = ptr;
                    ptr_upd = 1'b1;
                end
            end
            S_NEXT: begin
                if (!en) begin
                    d.st = S_IDLE;
                end else if (!pause) begin
                    d.st    = S_FETCH0;
                    d.desc  = ptr;
                    ptr_upd = 1'b1;
                end
            end
            S_FETCH0: begin
                mem_addr = q.desc;
                if (!en) begin
                    d.st = S_IDLE;
                end else if (!pause) begin
                    mem_req = 1'b1;
                    if (mem_rvalid) begin
                        d.cur = {mem_rdata[ADDR_W-1:2], 2'b00};
                        d.st  = S_FETCH1;
                    end
                end
            end
            S_FETCH1: begin
                mem_addr = q.desc + ADDR_W'(WORD_BYTES);
                if (!en) begin
                    d.st = S_IDLE;
                end else if (!pause) begin
                    mem_req = 1'b1;
                    if (mem_rvalid) begin
                        if (mem_rdata[FLAG_JMP]) begin
                            ptr_upd     = 1'b1;
                            ptr_upd_val = q.cur[ADDR_W-1:2];
                            d.st        = S_NEXT;
                        end else begin
                            if (mem_rdata[CNT_W-1:0] == '0) begin
                                d.rem = {1'b1, {CNT_W{1'b0}}};
                            end else begin
                                d.rem = {1'b0, mem_rdata[CNT_W-1:0]};
                            end
                            d.eot = mem_rdata[FLAG_EOT];
                            d.eop = mem_rdata[FLAG_EOP];
                            d.st  = S_DATA_RD;
                        end
                    end
                end
            end
            S_DATA_RD: begin
                mem_addr = q.cur;
                if (!en) begin
                    d.st = S_IDLE;
                end else if (!pause) begin
                    mem_req = 1'b1;
                    if (mem_rvalid) begin
                        d.word = mem_rdata;
                        d.st   = S_DATA_PUSH;
                    end
                end
            end
            S_DATA_PUSH: begin
                snd_valid = 1'b1;
                if (snd_ready) begin
                    d.cur = q.cur + ADDR_W'(WORD_BYTES);
                    if (last_word) begin
                        eop_event = q.eop;
                        if (q.eot) begin
                            d.st   = S_IDLE;
                            d.done = 1'b1;
                        end else if (!en) begin
                            d.st = S_IDLE;
                        end else begin
                            d.st = S_NEXT;
                        end
                    end else begin
                        d.rem = q.rem - REM_W'(WORD_BYTES);
                        d.st  = en ? S_DATA_RD : S_IDLE;
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    // R14: an unanswered request keeps its address
    p_req_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (!mem_req || $stable(mem_addr)));

    // R14: an unaccepted sample word stays on the codec side
    p_snd_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_valid && !snd_ready) |=> (snd_valid && $stable(snd_data)));

    // R10: the error pause blocks all memory traffic
    p_pause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pause |-> !mem_req);

    // R13: capture direction never leaves idle
    p_dir_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_IDLE && dir) |=> (q.st == S_IDLE));

endmodule

// File: rtl/audio_dma_engine.sv
module audio_dma_engine
    import adma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              snd_valid,
    output logic [DATA_W-1:0] snd_data,
    input  logic              snd_ready,
    output logic              irq
);

    logic              cmd_en;
    logic              cmd_dir;
    logic [ADDR_W-1:0] ptr;
    logic              err_flag;
    logic              ptr_upd;
    logic [ADDR_W-3:0] ptr_upd_val;
    logic              eop_event;

    adma_regs #(
        .ADDR_W (ADDR_W),
        .REG_W  (32)
    ) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr_en),
        .rd_en       (reg_rd_en),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .rdata       (reg_rdata),
        .cmd_en      (cmd_en),
        .cmd_dir     (cmd_dir),
        .ptr         (ptr),
        .err_flag    (err_flag),
        .irq         (irq),
        .ptr_upd     (ptr_upd),
        .ptr_upd_val (ptr_upd_val),
        .eop_event   (eop_event)
    );

    adma_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (cmd_en),
        .dir         (cmd_dir),
        .pause       (err_flag),
        .ptr         (ptr),
        .ptr_upd     (ptr_upd),
        .ptr_upd_val (ptr_upd_val),
        .eop_event   (eop_event),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_rvalid  (mem_rvalid),
        .mem_rdata   (mem_rdata),
        .snd_valid   (snd_valid),
        .snd_data    (snd_data),
        .snd_ready   (snd_ready)
    );

endmodule

// File: tb/audio_dma_engine_tb_top.sv
`timescale 1ns/1ps
module audio_dma_engine_tb_top;

    localparam logic [1:0]  A_CMD  = 2'd0;
    localparam logic [1:0]  A_STAT = 2'd1;
    localparam logic [1:0]  A_PTR  = 2'd2;
    localparam logic [31:0] F_EOT  = 32'h8000_0000;
    localparam logic [31:0] F_EOP  = 32'h4000_0000;
    localparam logic [31:0] F_JMP  = 32'h2000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = 32'd0;
    logic        snd_valid;
    logic [31:0] snd_data;
    logic        snd_ready = 1'b0;
    logic        irq;

    always #4 clk = ~clk;

    audio_dma_engine dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr_en  (reg_wr_en),
        .reg_rd_en  (reg_rd_en),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .snd_valid  (snd_valid),
        .snd_data   (snd_data),
        .snd_ready  (snd_ready),
        .irq        (irq)
    );

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    int unsigned got = 0;
    int unsigned req_cycles = 0;
    int unsigned hold_viol = 0;
    int unsigned lat = 0;
    bit          finished = 1'b0;
    logic        prev_v = 1'b0;
    logic        prev_r = 1'b0;
    logic [31:0] prev_d = 32'd0;
    logic [31:0] exp_w;
    logic [31:0] dmem [logic [31:0]];
    logic [31:0] expq [$];

    function automatic logic [31:0] pat(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'hC0DE_A55A;
    endfunction

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        if (dmem.exists(a)) return dmem[a];
        return pat(a);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // memory model, codec sink and stream checker (R5, R14)
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (prev_v && prev_r) begin
                    got++;
                    if (expq.size() == 0) begin
                        chk("R5 unexpected word", prev_d, 32'hxxxx_xxxx);
                    end else begin
                        exp_w = expq.pop_front();
                        chk("R5 stream word", prev_d, exp_w);
                    end
                end
                if (prev_v && !prev_r && (!snd_valid || snd_data !== prev_d)) hold_viol++;
                if (mem_req) req_cycles++;
                if (mem_rvalid) begin
                    mem_rvalid = 1'b0;
                    lat = $urandom % 2;
                end else if (mem_req) begin
                    if (lat == 0) begin
                        mem_rvalid = 1'b1;
                        mem_rdata  = mem_rd(mem_addr);
                    end else begin
                        lat--;
                    end
                end else begin
                    lat = $urandom % 2;
                end
                prev_v    = snd_valid;
                prev_d    = snd_data;
                snd_ready = ($urandom % 4) != 0;
                prev_r    = snd_ready;
            end
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        summary();
    end

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_rd_en = 1'b1;
        reg_addr  = a;
        #1;
        v = reg_rdata;
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    task automatic put_desc(input logic [31:0] at, input logic [31:0] w0, input logic [31:0] w1);
        dmem[at]      = w0;
        dmem[at + 4]  = w1;
    endtask

    task automatic exp_region(input logic [31:0] base, input int cnt);
        int n;
        n = (cnt == 0) ? 16384 : (cnt + 3) / 4;
        for (int i = 0; i < n; i++) expq.push_back(pat(base + 32'(4 * i)));
    endtask

    task automatic wait_drain(input int maxc);
        int c;
        c = 0;
        while (expq.size() != 0 && c < maxc) begin
            @(negedge clk);
            c++;
        end
        repeat (20) @(negedge clk);
    endtask

    task automatic wait_got(input int unsigned target, input int maxc);
        int c;
        c = 0;
        while (got < target && c < maxc) begin
            @(negedge clk);
            c++;
        end
    endtask

    logic [31:0] rv;
    int unsigned snap_req;
    int unsigned snap_got;
    int unsigned g0;

    initial begin
        void'($urandom(32'd20245));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
        chk("R1 snd_valid", {31'd0, snd_valid}, 32'd0);
        reg_rd(A_CMD, rv);  chk("R1 cmd", rv, 32'd0);
        reg_rd(A_STAT, rv); chk("R1 status", rv, 32'd0);
        reg_rd(A_PTR, rv);  chk("R1 ptr", rv, 32'd0);

        // R2 command masking, R3 pointer alignment
        for (int i = 0; i < 6; i++) begin
            logic [31:0] v;
            v = $urandom & 32'hFFFF_FFFE;
            reg_wr(A_CMD, v);
            reg_rd(A_CMD, rv);
            chk("R2 cmd readback", rv, v & 32'h0000_0008);
            v = $urandom;
            reg_wr(A_PTR, v);
            reg_rd(A_PTR, rv);
            chk("R3 ptr readback", rv, v & 32'hFFFF_FFFC);
        end
        reg_wr(A_CMD, 32'd0);

        // directed table: page region, jump with unaligned target, rounded last region
        put_desc(32'h0000_1000, 32'h0100_0000, F_EOP | 32'd12);
        put_desc(32'h0000_1008, 32'h0000_2001, F_JMP);
        put_desc(32'h0000_2000, 32'h0100_1000, F_EOT | 32'd6);
        exp_region(32'h0100_0000, 12);
        exp_region(32'h0100_1000, 6);
        reg_wr(A_PTR, 32'h0000_1000);
        reg_wr(A_CMD, 32'h0000_0001);
        reg_rd(A_PTR, rv);
        chk("R4 pointer advanced on start", rv, 32'h0000_1008);
        wait_drain(2000);
        chk("R5 all words delivered", expq.size(), 32'd0);
        reg_rd(A_PTR, rv);
        chk("R7 pointer after jump", rv, 32'h0000_2008);
        chk("R9 irq on page end", {31'd0, irq}, 32'd1);
        reg_rd(A_CMD, rv);
        chk("R8 enable kept after table end", rv, 32'd1);
        snap_req = req_cycles;
        repeat (40) @(negedge clk);
        chk("R8 no requests after table end", req_cycles, snap_req);
        reg_rd(A_STAT, rv);
        chk("R9 page status bit", rv, 32'd1);
        reg_rd(A_STAT, rv);
        chk("R11 status cleared by read", rv, 32'd0);
        chk("R11 irq low after read", {31'd0, irq}, 32'd0);

        // R6 zero byte count, R8 rearm
        reg_wr(A_CMD, 32'd0);
        put_desc(32'h0000_3000, 32'h0200_0000, F_EOT);
        g0 = got;
        exp_region(32'h0200_0000, 0);
        reg_wr(A_PTR, 32'h0000_3000);
        reg_wr(A_CMD, 32'd1);
        wait_drain(130000);
        chk("R6 zero count word total", got - g0, 32'd16384);
        chk("R8 rearm drained", expq.size(), 32'd0);

        // R10 second page event pauses
        reg_wr(A_CMD, 32'd0);
        put_desc(32'h0000_4000, 32'h0300_0000, F_EOP | 32'd8);
        put_desc(32'h0000_4008, 32'h0300_0100, F_EOP | 32'd8);
        put_desc(32'h0000_4010, 32'h0300_0200, F_EOT | 32'd4);
        g0 = got;
        exp_region(32'h0300_0000, 8);
        exp_region(32'h0300_0100, 8);
        exp_region(32'h0300_0200, 4);
        reg_wr(A_PTR, 32'h0000_4000);
        reg_wr(A_CMD, 32'd1);
        wait_got(g0 + 4, 2000);
        repeat (10) @(negedge clk);
        snap_req = req_cycles;
        repeat (60) @(negedge clk);
        chk("R10 no requests while paused", req_cycles, snap_req);
        chk("R10 words before pause", got - g0, 32'd4);
        chk("R10 irq while paused", {31'd0, irq}, 32'd1);
        reg_rd(A_STAT, rv);
        chk("R10 both status bits", rv, 32'd3);
        wait_drain(2000);
        chk("R10 resumed after read", got - g0, 32'd5);
        reg_rd(A_STAT, rv);
        chk("R11 status clear after resume", rv, 32'd0);

        // R12 abort on enable clear
        reg_wr(A_CMD, 32'd0);
        put_desc(32'h0000_5000, 32'h0400_0000, F_EOT | 32'd400);
        g0 = got;
        exp_region(32'h0400_0000, 400);
        reg_wr(A_PTR, 32'h0000_5000);
        reg_wr(A_CMD, 32'd1);
        wait_got(g0 + 10, 2000);
        reg_wr(A_CMD, 32'd0);
        repeat (10) @(negedge clk);
        snap_req = req_cycles;
        snap_got = got;
        repeat (40) @(negedge clk);
        chk("R12 no requests after abort", req_cycles, snap_req);
        chk("R12 no words after abort", got, snap_got);
        chk("R12 transfer cut short", {31'd0, (got - g0) < 100}, 32'd1);
        expq.delete();

        // R13 capture direction does not start
        reg_wr(A_PTR, 32'h0000_3000);
        snap_req = req_cycles;
        snap_got = got;
        reg_wr(A_CMD, 32'h0000_0009);
        repeat (40) @(negedge clk);
        chk("R13 no requests", req_cycles, snap_req);
        chk("R13 no words", got, snap_got);
        reg_rd(A_PTR, rv);
        chk("R13 pointer not advanced", rv, 32'h0000_3000);
        reg_rd(A_CMD, rv);
        chk("R13 cmd readback", rv, 32'h0000_0009);
        reg_wr(A_CMD, 32'd0);

        // random tables with random counts and jumps (R5, R7, R8)
        for (int it = 0; it < 6; it++) begin
            logic [31:0] tbase;
            logic [31:0] cur;
            logic [31:0] base;
            logic [31:0] tgt;
            int nreg;
            int cnt;
            tbase = 32'h0001_0000 + 32'(it) * 32'h1000;
            cur   = tbase;
            nreg  = 1 + int'($urandom % 4);
            for (int k = 0; k < nreg; k++) begin
                cnt = 1 + int'($urandom % 64);
                if ($urandom % 2 == 1) begin
                    tgt = tbase + 32'h100 * 32'(k + 1);
                    put_desc(cur, tgt, F_JMP);
                    cur = tgt;
                end
                base = 32'h0500_0000 + 32'(it) * 32'h1_0000 + 32'(k) * 32'h400;
                put_desc(cur, base, ((k == nreg - 1) ? F_EOT : 32'd0) | 32'(cnt));
                exp_region(base, cnt);
                cur = cur + 32'd8;
            end
            reg_wr(A_PTR, tbase);
            reg_wr(A_CMD, 32'd1);
            wait_drain(20000);
            chk("R5 random table drained", expq.size(), 32'd0);
            reg_rd(A_PTR, rv);
            chk("R8 pointer after random table", rv, cur);
            reg_wr(A_CMD, 32'd0);
        end

        chk("R14 codec word held until accepted", hold_viol, 32'd0);
        summary();
    end

endmodule